// File: doc/BRIEF.md
# Host Register Access Unit with Write Guard

This block sits between a host processor and the receive/transmit state machines of a token-ring media access controller. It decodes single-cycle host reads and writes to a small bank of 16-bit registers: a receive control word that the host may change at any time, a configuration word that may only be changed while the state machines are halted, a status word that clears on read, and a fixed identification word. Every host access is acknowledged one cycle later, whether or not it was legal.

A write that the bank must refuse still finishes as a normal bus cycle. It changes no register and instead sets a sticky error flag in the status word. Bit 15 of the receive control word is the run bit. It drives a level enable to the state machines and a one-cycle start pulse when it goes from 0 to 1. A synchronous power-up reset clears everything. A separate soft MAC reset clears only the configuration word.

Top module: `mac_host_regs`

## Requirements
- R1: After power-up reset, `host_rdy`, `host_rdata`, `mac_en`, `mac_start` and `mac_cfg` are zero, and reads of the control word (address 0) and the status word (address 2) return 0.
- R2: `host_rdy` is high in exactly the cycle after each cycle in which `host_rd` or `host_wr` is high, for legal and illegal accesses alike, and is low otherwise.
- R3: The control word at address 0 may be written at any time. It reads back as the written value with bits 7:6 forced to zero (mask 16'hFF3F). The hardware never changes it.
- R4: `mac_en` equals bit 15 of the control word. `mac_start` is high for one cycle, the first cycle in which `mac_en` is high after a write that sets bit 15 while it was clear. Rewriting bit 15 as 1 while it is already 1 gives no pulse.
- R5: The configuration word at address 1 (mask 16'h00FF, driven on `mac_cfg`) takes a write only while bit 15 of the control word is clear. A legal write does not set the error flag.
- R6: A write to address 1 while bit 15 of the control word is set leaves `mac_cfg` unchanged and sets the error flag.
- R7: A write to the status word (address 2), to the identification word (address 3), or to any unmapped address (4 to 15) changes no register and sets the error flag.
- R8: A read of address 2 returns {14'b0, run bit, error flag} in bits {15:2, 1, 0}. The flag clears after that read. If an illegal write occurs in the same cycle as the clearing read, the flag stays set, and the read returns the value from before the cycle.
- R9: The soft reset clears `mac_cfg` and leaves the control word and the error flag unchanged.
- R10: A read of address 3 returns 16'h5A31. A read of an unmapped address returns 0.
- R11: `host_rdata` carries the read value only in the cycle after a read strobe and is zero in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-up reset, synchronous, active high |
| soft_rst | input | 1 | Soft MAC reset, clears the configuration word only |
| host_addr | input | 4 | Register address |
| host_wdata | input | 16 | Write data |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rdata | output | 16 | Read data, valid while `host_rdy` follows a read |
| host_rdy | output | 1 | Access acknowledge, one cycle after a strobe |
| mac_en | output | 1 | Run level to the state machines |
| mac_start | output | 1 | One-cycle start pulse on the run bit rising |
| mac_cfg | output | 16 | Configuration word to the state machines |

## Verification
The clear-on-read of the error flag and the setting of that flag by a refused write can land on the same clock edge. The bench provokes this by raising both strobes at address 2 in one cycle. It expects the response to show the flag as it stood before the cycle, and a following status read to show the flag still set. A second coincidence is a soft reset while the run bit and the error flag hold values. Follow-up reads then show that only the configuration word was cleared.

// File: rtl/mhr_pkg.sv
package mhr_pkg;
  typedef enum logic [2:0] {
    K_CTRL,
    K_CFG,
    K_STAT,
    K_ID,
    K_NONE
  } reg_kind_e;

  localparam int unsigned A_CTRL = 0;
  localparam int unsigned A_CFG  = 1;
  localparam int unsigned A_STAT = 2;
  localparam int unsigned A_ID   = 3;

  localparam int unsigned STAT_ERR_POS = 0;
  localparam int unsigned STAT_RUN_POS = 1;
endpackage

// File: rtl/mhr_decode.sv
module mhr_decode
  import mhr_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter bit          HAS_ID = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic              running,
  output reg_kind_e         kind,
  output logic              wr_ctrl,
  output logic              wr_cfg,
  output logic              wr_bad,
  output logic              rd_stat
);
  localparam logic [ADDR_W-1:0] AD_CTRL = ADDR_W'(A_CTRL);
  localparam logic [ADDR_W-1:0] AD_CFG  = ADDR_W'(A_CFG);
  localparam logic [ADDR_W-1:0] AD_STAT = ADDR_W'(A_STAT);
  localparam logic [ADDR_W-1:0] AD_ID   = ADDR_W'(A_ID);

  logic cfg_open;

  always_comb begin
    kind = K_NONE;
    if (addr == AD_CTRL)               kind = K_CTRL;
    else if (addr == AD_CFG)           kind = K_CFG;
    else if (addr == AD_STAT)          kind = K_STAT;
    else if (HAS_ID && addr == AD_ID)  kind = K_ID;
  end

  assign cfg_open = (kind == K_CFG) && !running;
  assign wr_ctrl  = wr && (kind == K_CTRL);
  assign wr_cfg   = wr && cfg_open;
  assign wr_bad   = wr && (kind != K_CTRL) && !cfg_open;
  assign rd_stat  = rd && (kind == K_STAT);
endmodule

// File: rtl/mhr_ctrl_reg.sv
module mhr_ctrl_reg #(
  parameter int unsigned          DATA_W    = 16,
  parameter int unsigned          RUN_BIT   = 15,
  parameter logic [DATA_W-1:0]    CTRL_MASK = 16'hFF3F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              run_en,
  output logic              run_start
);
  logic run_req;

  assign run_req = wdata[RUN_BIT] & CTRL_MASK[RUN_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      run_start <= 1'b0;
    end else begin
      run_start <= wr && run_req && !ctrl_q[RUN_BIT];
      if (wr) ctrl_q <= wdata & CTRL_MASK;
    end
  end

  assign run_en = ctrl_q[RUN_BIT];
endmodule

// File: rtl/mhr_cfg_reg.sv
module mhr_cfg_reg #(
  parameter int unsigned       DATA_W   = 16,
  parameter logic [DATA_W-1:0] CFG_MASK = 16'h00FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cfg_q
);
  always_ff @(posedge clk) begin
    if (rst || soft_rst) cfg_q <= '0;
    else if (wr)         cfg_q <= wdata & CFG_MASK;
  end
endmodule

// File: rtl/mhr_status.sv
module mhr_status (
  input  logic clk,
  input  logic rst,
  input  logic set_err,
  input  logic clr_err,
  output logic err_q
);
  always_ff @(posedge clk) begin
    if (rst)          err_q <= 1'b0;
    else if (set_err) err_q <= 1'b1;
    else if (clr_err) err_q <= 1'b0;
  end
endmodule

// File: rtl/mac_host_regs.sv
module mac_host_regs
  import mhr_pkg::*;
#(
  parameter int unsigned       DATA_W    = 16,
  parameter int unsigned       ADDR_W    = 4,
  parameter int unsigned       RUN_BIT   = 15,
  parameter logic [DATA_W-1:0] CTRL_MASK = 16'hFF3F,
  parameter logic [DATA_W-1:0] CFG_MASK  = 16'h00FF,
  parameter logic [DATA_W-1:0] ID_VALUE  = 16'h5A31,
  parameter bit                HAS_ID    = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_rd,
  input  logic              host_wr,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rdy,
  output logic              mac_en,
  output logic              mac_start,
  output logic [DATA_W-1:0] mac_cfg
);
  reg_kind_e         kind;
  logic              wr_ctrl, wr_cfg, wr_bad, rd_stat;
  logic              err_q;
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] stat_word;
  logic [DATA_W-1:0] id_word;
  logic [DATA_W-1:0] rd_mux;

  mhr_decode #(.ADDR_W(ADDR_W), .HAS_ID(HAS_ID)) u_dec (
    .addr   (host_addr),
    .rd     (host_rd),
    .wr     (host_wr),
    .running(mac_en),
    .kind   (kind),
    .wr_ctrl(wr_ctrl),
    .wr_cfg (wr_cfg),
    .wr_bad (wr_bad),
    .rd_stat(rd_stat)
  );

  mhr_ctrl_reg #(.DATA_W(DATA_W), .RUN_BIT(RUN_BIT), .CTRL_MASK(CTRL_MASK)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr       (wr_ctrl),
    .wdata    (host_wdata),
    .ctrl_q   (ctrl_q),
    .run_en   (mac_en),
    .run_start(mac_start)
  );

  mhr_cfg_reg #(.DATA_W(DATA_W), .CFG_MASK(CFG_MASK)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .soft_rst(soft_rst),
    .wr      (wr_cfg),
    .wdata   (host_wdata),
    .cfg_q   (mac_cfg)
  );

  mhr_status u_stat (
    .clk    (clk),
    .rst    (rst),
    .set_err(wr_bad),
    .clr_err(rd_stat),
    .err_q  (err_q)
  );

  generate
    if (HAS_ID) begin : g_id
      assign id_word = ID_VALUE;
    end else begin : g_no_id
      assign id_word = '0;
    end
  endgenerate

  always_comb begin
    stat_word               = '0;
    stat_word[STAT_ERR_POS] = err_q;
    stat_word[STAT_RUN_POS] = mac_en;
  end

  always_comb begin
    unique case (kind)
      K_CTRL:  rd_mux = ctrl_q;
      K_CFG:   rd_mux = mac_cfg;
      K_STAT:  rd_mux = stat_word;
      K_ID:    rd_mux = id_word;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdy   <= 1'b0;
      host_rdata <= '0;
    end else begin
      host_rdy   <= host_rd || host_wr;
      host_rdata <= host_rd ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/mhr_checker.sv
module mhr_checker #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              soft_rst,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_rd,
  input logic              host_wr,
  input logic [DATA_W-1:0] host_rdata,
  input logic              host_rdy,
  input logic              mac_en,
  input logic              mac_start,
  input logic [DATA_W-1:0] mac_cfg,
  input logic [DATA_W-1:0] ctrl_q,
  input logic              err_q
);
  localparam logic [ADDR_W-1:0] STAT_AD = ADDR_W'(mhr_pkg::A_STAT);

  p_rdy_after_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    (host_rd || host_wr) |=> host_rdy);

  p_rdy_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !(host_rd || host_wr) |=> !host_rdy);

  p_start_single_r4: assert property (@(posedge clk) disable iff (rst)
    mac_start |=> !mac_start);

  p_start_on_rise_r4: assert property (@(posedge clk) disable iff (rst)
    mac_start |-> (mac_en && !$past(mac_en)));

  p_cfg_locked_r6: assert property (@(posedge clk) disable iff (rst)
    (mac_en && !soft_rst) |=> $stable(mac_cfg));

  p_stat_write_flags_r7: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == STAT_AD) |=> err_q);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (err_q && !(host_rd && host_addr == STAT_AD)) |=> err_q);

  p_soft_keeps_ctrl_r9: assert property (@(posedge clk) disable iff (rst)
    (soft_rst && !host_wr) |=> $stable(ctrl_q));

  p_rdata_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> (host_rdata == '0));
endmodule

bind mac_host_regs mhr_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .soft_rst  (soft_rst),
  .host_addr (host_addr),
  .host_rd   (host_rd),
  .host_wr   (host_wr),
  .host_rdata(host_rdata),
  .host_rdy  (host_rdy),
  .mac_en    (mac_en),
  .mac_start (mac_start),
  .mac_cfg   (mac_cfg),
  .ctrl_q    (ctrl_q),
  .err_q     (err_q)
);

// File: tb/mac_host_regs_test.sv
module mac_host_regs_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        soft_rst = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic        host_rd = 1'b0;
  logic        host_wr = 1'b0;
  logic [15:0] host_rdata;
  logic        host_rdy;
  logic        mac_en;
  logic        mac_start;
  logic [15:0] mac_cfg;

  int n_chk = 0;
  int n_fail = 0;
  bit armed = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_host_regs uut (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_wr(host_wr),
    .host_rdata(host_rdata), .host_rdy(host_rdy),
    .mac_en(mac_en), .mac_start(mac_start), .mac_cfg(mac_cfg)
  );

  // behavioural reference state
  logic [15:0] m_ctrl, m_cfg, m_rdata, m_rd_val;
  logic        m_err, m_err_nx, m_rdy, m_start, m_run;

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = 0; m_cfg = 0; m_rdata = 0; m_err = 0; m_rdy = 0; m_start = 0;
    end else begin
      m_run    = m_ctrl[15];
      m_rdy    = host_rd | host_wr;
      m_start  = 0;
      m_rd_val = 0;
      case (host_addr)
        4'd0: m_rd_val = m_ctrl;
        4'd1: m_rd_val = m_cfg;
        4'd2: m_rd_val = {14'b0, m_run, m_err};
        4'd3: m_rd_val = 16'h5A31;
        default: m_rd_val = 0;
      endcase
      m_rdata  = host_rd ? m_rd_val : 16'h0;
      m_err_nx = m_err;
      if (host_rd && host_addr == 4'd2) m_err_nx = 0;
      if (host_wr) begin
        if (host_addr == 4'd0) begin
          if (host_wdata[15] && !m_run) m_start = 1;
          m_ctrl = host_wdata & 16'hFF3F;
        end else if (host_addr == 4'd1 && !m_run) begin
          m_cfg = host_wdata & 16'h00FF;
        end else begin
          m_err_nx = 1;
        end
      end
      if (soft_rst) m_cfg = 0;
      m_err = m_err_nx;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (armed && !done) begin
      chk("R2 host_rdy",    {15'b0, host_rdy},  {15'b0, m_rdy});
      chk("R4 mac_start",   {15'b0, mac_start}, {15'b0, m_start});
      chk("R4 mac_en",      {15'b0, mac_en},    {15'b0, m_ctrl[15]});
      chk("R5 mac_cfg",     mac_cfg,            m_cfg);
      chk("R11 host_rdata", host_rdata,         m_rdata);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input string tag, input logic [15:0] exp);
    @(negedge clk); host_addr = a; host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0;
    chk(tag, host_rdata, exp);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog: actual=hung expected=complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    armed = 1'b1;
    // R1 reset state
    chk("R1 rdata", host_rdata, 16'h0);
    chk("R1 rdy", {15'b0, host_rdy}, 16'h0);
    chk("R1 cfg", mac_cfg, 16'h0);
    rd(4'd0, "R1 ctrl after reset", 16'h0000);
    rd(4'd2, "R1 status after reset", 16'h0000);
    // R3 masking of undefined bits
    wr(4'd0, 16'h00FF);
    rd(4'd0, "R3 ctrl mask", 16'h003F);
    // R5 legal config write while halted
    wr(4'd1, 16'hABCD);
    rd(4'd1, "R5 cfg write halted", 16'h00CD);
    rd(4'd2, "R5 no error on legal write", 16'h0000);
    // R4 start pulse
    wr(4'd0, 16'h8001);
    chk("R4 start high", {15'b0, mac_start}, 16'h1);
    chk("R4 en high", {15'b0, mac_en}, 16'h1);
    @(negedge clk);
    chk("R4 start single", {15'b0, mac_start}, 16'h0);
    // R6 config locked while running
    wr(4'd1, 16'h0012);
    rd(4'd1, "R6 cfg unchanged", 16'h00CD);
    rd(4'd2, "R8 status err+run", 16'h0003);
    rd(4'd2, "R8 err cleared by read", 16'h0002);
    // R4 rewrite without pulse, R3 write while running
    wr(4'd0, 16'h8002);
    chk("R4 no second start", {15'b0, mac_start}, 16'h0);
    rd(4'd0, "R3 ctrl write while running", 16'h8002);
    // R7 refused writes
    wr(4'd2, 16'hFFFF);
    rd(4'd2, "R7 status write flags", 16'h0003);
    wr(4'd3, 16'h0000);
    rd(4'd2, "R7 id write flags", 16'h0003);
    rd(4'd3, "R7 id unchanged R10", 16'h5A31);
    wr(4'd4, 16'h1234);
    rd(4'd2, "R7 unmapped 4 flags", 16'h0003);
    wr(4'd15, 16'h5555);
    rd(4'd2, "R7 unmapped 15 flags", 16'h0003);
    rd(4'd9, "R10 unmapped read zero", 16'h0000);
    // R9 soft reset
    wr(4'd7, 16'h0001);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    chk("R9 cfg cleared", mac_cfg, 16'h0000);
    rd(4'd2, "R9 err kept", 16'h0003);
    rd(4'd0, "R9 ctrl kept", 16'h8002);
    // R8 clearing read and refused write in one cycle
    @(negedge clk); host_addr = 4'd2; host_rd = 1'b1; host_wr = 1'b1;
    @(negedge clk); host_rd = 1'b0; host_wr = 1'b0;
    chk("R8 same-cycle read value", host_rdata, 16'h0002);
    rd(4'd2, "R8 set wins over clear", 16'h0003);
    rd(4'd2, "R8 cleared afterwards", 16'h0002);
    // stop, then config opens again
    wr(4'd0, 16'h0000);
    chk("R4 en low after clear", {15'b0, mac_en}, 16'h0);
    wr(4'd1, 16'h1177);
    rd(4'd1, "R5 cfg write after stop", 16'h0077);
    rd(4'd2, "R5 no error after stop", 16'h0000);
    // back-to-back reads
    @(negedge clk); host_addr = 4'd3; host_rd = 1'b1;
    @(negedge clk); host_addr = 4'd1;
    @(negedge clk); host_rd = 1'b0;
    chk("R2 back-to-back rdy", {15'b0, host_rdy}, 16'h1);
    chk("R11 second read data", host_rdata, 16'h0077);
    // power-up reset mid-run
    wr(4'd0, 16'h80FF);
    wr(4'd5, 16'h0000);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    rd(4'd0, "R1 ctrl cleared by reset", 16'h0000);
    rd(4'd2, "R1 err cleared by reset", 16'h0000);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule